// File: doc/BRIEF.md
# UART Baud Rate Generator

This block supplies the bit-timing enable for a UART transmitter and receiver. An 8-bit control register picks one of four base clocks: the rising edges of a square-wave input from an external timer, or the main clock divided by 2, 8 or 32. An integer divisor k then divides the chosen base clock. The result is a single-cycle enable pulse, `baudTick`, in the main clock domain. The UART logic uses it as a clock enable. It is never used as a clock.

The register is written through a one-cycle write strobe, and it can be read back at all times. Each write restarts the prescaler and the divide-by-k counter, so the rate after a reprogram is exact from the first pulse. A divisor below 8 is an illegal setting. For such a value the block raises `cfgError` and produces no pulses.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the register reads 0x1F (external timer source, k = 31), `baudTick` is low and `cfgError` is low.
- R2: A write stores bits 7:6 and 4:0 of `wrData`. Bit 5 always reads back as 0, and the stored value is visible on `rdData` the cycle after the write edge.
- R3: Bits 7:6 select the base clock: 00 = rising edges of `timerIn`, 01 = main clock / 2, 10 = main clock / 8, 11 = main clock / 32.
- R4: With a legal divisor k (bits 4:0) and a prescaled source of ratio N, `baudTick` is a one-cycle pulse that repeats every k*N main clock cycles.
- R5: A write restarts all counting. The first pulse appears k*N clock edges after the write edge, and `baudTick` is low in the cycle after a write.
- R6: A divisor in the range 0 to 7 (bits 4:3 = 00) sets `cfgError` high, and `baudTick` stays low while the setting is in place.
- R7: Any divisor in the range 8 to 31 keeps `cfgError` low.
- R8: With source 00, each rising edge of `timerIn` counts as one base period, so pulses repeat every k periods of `timerIn`. Each high and low phase of `timerIn` lasts at least one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle |
| wrData | input | 8 | Register write value |
| rdData | output | 8 | Register contents, bit 5 forced to 0 |
| timerIn | input | 1 | External timer square wave, asynchronous |
| baudTick | output | 1 | One-cycle baud enable pulse |
| cfgError | output | 1 | High while the stored divisor is below 8 |

## Verification
The hardest case to reach is the external timer source. Its pulse timing depends on how the asynchronous `timerIn` phase lines up with the two-stage synchronizer and the divide-by-k counter, and the ports give no direct view of either. The bench runs `timerIn` from a free-running toggler started at a chosen point after a write. A behavioural model follows every sampled timer value through the synchronizer delay. This makes both the absolute pulse cycles and the k-period spacing checkable. The prescaled sources are covered by rewriting the register mid-count and timing the first pulse from the write edge.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  localparam int CTRL_W = 8;
  localparam int SEL_W  = 2;
  localparam int DIV_W  = 5;

  typedef struct packed {
    logic             restart;
    logic [SEL_W-1:0] srcSel;
    logic [DIV_W-1:0] divisor;
    logic             divLegal;
  } ctrlStrobes_t;
endpackage

// File: rtl/baud_tick_ctrl.sv
module baud_tick_ctrl
  import baud_tick_pkg::*;
#(
  parameter logic [CTRL_W-1:0] RESET_VAL = 8'h1F,
  parameter int                MIN_DIV   = 8,
  parameter int                SPARE_BIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  output logic [CTRL_W-1:0] rdData,
  output logic              cfgError,
  output ctrlStrobes_t      strb
);
  localparam logic [CTRL_W-1:0] KEEP_MASK = ~(CTRL_W'(1) << SPARE_BIT);
  localparam int SEL_LSB = CTRL_W - SEL_W;

  logic [CTRL_W-1:0] ctrlReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     ctrlReg <= RESET_VAL & KEEP_MASK;
    else if (wrEn) ctrlReg <= wrData & KEEP_MASK;
  end

  always_comb begin
    strb.restart  = wrEn;
    strb.srcSel   = ctrlReg[CTRL_W-1:SEL_LSB];
    strb.divisor  = ctrlReg[DIV_W-1:0];
    strb.divLegal = (int'(ctrlReg[DIV_W-1:0]) >= MIN_DIV);
  end

  assign rdData   = ctrlReg;
  assign cfgError = !strb.divLegal;
endmodule

// File: rtl/baud_tick_datapath.sv
module baud_tick_datapath
  import baud_tick_pkg::*;
#(
  parameter int TAP0_LOG = 1,
  parameter int TAP1_LOG = 3,
  parameter int TAP2_LOG = 5,
  parameter int SYNC_LEN = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strb,
  input  logic         timerIn,
  output logic         baudTick
);
  localparam int NUM_TAPS = 3;
  localparam int PRE_W    = TAP2_LOG;

  function automatic int tapLog(input int idx);
    case (idx)
      0:       return TAP0_LOG;
      1:       return TAP1_LOG;
      default: return TAP2_LOG;
    endcase
  endfunction

  logic [PRE_W-1:0]    preCnt;
  logic [NUM_TAPS-1:0] tapEn;
  logic [SYNC_LEN:0]   tmrHist;
  logic                tmrEdge;
  logic                baseEn;
  logic [DIV_W-1:0]    divCnt;
  logic                divWrap;
  logic                tickQ;

  // free-running prescaler, cleared by a register write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             preCnt <= '0;
    else if (strb.restart) preCnt <= '0;
    else                   preCnt <= preCnt + PRE_W'(1);
  end

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    assign tapEn[t] = &preCnt[tapLog(t)-1:0];
  end

  // synchronizer plus one extra stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tmrHist <= '0;
    else       tmrHist <= {tmrHist[SYNC_LEN-1:0], timerIn};
  end
  assign tmrEdge = tmrHist[SYNC_LEN-1] & ~tmrHist[SYNC_LEN];

  always_comb begin
    case (strb.srcSel)
      2'd0:    baseEn = tmrEdge;
      2'd1:    baseEn = tapEn[0];
      2'd2:    baseEn = tapEn[1];
      default: baseEn = tapEn[2];
    endcase
  end

  assign divWrap = (divCnt == strb.divisor - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              divCnt <= '0;
    else if (strb.restart || !strb.divLegal) divCnt <= '0;
    else if (baseEn)                        divCnt <= divWrap ? '0 : divCnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             tickQ <= 1'b0;
    else if (strb.restart) tickQ <= 1'b0;
    else                   tickQ <= baseEn && strb.divLegal && divWrap;
  end

  assign baudTick = tickQ;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter logic [CTRL_W-1:0] RESET_VAL = 8'h1F,
  parameter int                MIN_DIV   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  output logic [CTRL_W-1:0] rdData,
  input  logic              timerIn,
  output logic              baudTick,
  output logic              cfgError
);
  ctrlStrobes_t strb;

  baud_tick_ctrl #(.RESET_VAL(RESET_VAL), .MIN_DIV(MIN_DIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .cfgError(cfgError), .strb(strb)
  );

  baud_tick_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .timerIn(timerIn), .baudTick(baudTick)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       baudTick,
  input logic       cfgError
);
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |=> !baudTick);

  p_quiet_on_error_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> !baudTick);

  p_error_tracks_code_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgError == (rdData[4:3] == 2'b00));

  p_spare_bit_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[5]);

  p_readback_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData == ($past(wrData) & 8'hDF));

  p_write_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !baudTick);
endmodule

bind baud_tick_gen baud_tick_gen_chk chk_i (.*);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       timerIn = 1'b0;
  logic       baudTick;
  logic       cfgError;

  int testsRun = 0;
  int testsFailed = 0;
  bit tmrRun = 0;
  int tmrCnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  baud_tick_gen dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .timerIn(timerIn), .baudTick(baudTick), .cfgError(cfgError)
  );

  // behavioural reference model
  int mReg, mPre, mDiv, mTick;
  bit h0, h1, h2;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReg = 'h1F; mPre = 0; mDiv = 0; mTick = 0; h0 = 0; h1 = 0; h2 = 0;
    end else begin
      int k, n, sel;
      bit be, legal, nextTick;
      k = mReg % 32; sel = mReg / 64; legal = (k >= 8);
      n = (sel == 1) ? 2 : (sel == 2) ? 8 : 32;
      be = (sel == 0) ? (h1 && !h2) : ((mPre % n) == n - 1);
      nextTick = be && legal && (mDiv == k - 1);
      if (wrEn) begin
        mReg = wrData & 'hDF; mPre = 0; mDiv = 0; mTick = 0;
      end else begin
        mPre = (mPre + 1) % 32;
        if (!legal) mDiv = 0;
        else if (be) mDiv = (mDiv == k - 1) ? 0 : mDiv + 1;
        mTick = nextTick;
      end
      h2 = h1; h1 = h0; h0 = timerIn;
    end
  end

  // per-cycle comparison against the model (R4, R8)
  always @(negedge clk) begin
    if (rstN && !done) begin
      testsRun++;
      if (baudTick !== mTick[0]) begin
        testsFailed++;
        $display("FAIL R4/R8 per-cycle tick: actual %0b expected %0b at %0t", baudTick, mTick[0], $time);
      end
    end
  end

  // external timer toggler, half period of 3 clocks
  initial forever begin
    @(negedge clk);
    if (tmrRun) begin
      tmrCnt++;
      if (tmrCnt == 3) begin timerIn = ~timerIn; tmrCnt = 0; end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // counts negedges until a tick is seen, starting at the current negedge
  task automatic waitTick(input int limit, output int cnt);
    cnt = 0;
    while (baudTick !== 1'b1 && cnt < limit) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic runRate(input logic [7:0] v, input int expPeriod, input string tag);
    int c;
    writeReg(v);
    check(baudTick === 1'b0, {tag, " R5 low after write"}, baudTick, 0);
    check(rdData === (v & 8'hDF), {tag, " R2 readback"}, rdData, v & 8'hDF);
    check(cfgError === 1'b0, {tag, " R7 legal divisor"}, cfgError, 0);
    waitTick(expPeriod + 10, c);
    check(c == expPeriod, {tag, " R5 first tick"}, c, expPeriod);
    @(negedge clk);
    waitTick(expPeriod + 10, c);
    check(c == expPeriod - 1, {tag, " R4 R3 period"}, c + 1, expPeriod);
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    check(rdData === 8'h1F, "R1 reset value", rdData, 'h1F);
    check(baudTick === 1'b0, "R1 tick low", baudTick, 0);
    check(cfgError === 1'b0, "R1 error low", cfgError, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(rdData === 8'h1F, "R1 value after release", rdData, 'h1F);

    runRate(8'h48, 16, "div2 k8");
    runRate(8'h9F, 248, "div8 k31");
    runRate(8'hCA, 320, "div32 k10");
    runRate(8'h7F, 62, "div2 k31 spare bit set");
    // restart mid-count (R5)
    repeat (20) @(negedge clk);
    runRate(8'h7F, 62, "div2 k31 rewrite");

    // illegal divisors (R6)
    writeReg(8'h47);
    check(cfgError === 1'b1, "R6 error k7", cfgError, 1);
    check(rdData === 8'h47, "R2 readback k7", rdData, 'h47);
    waitTick(400, c);
    check(c == 400, "R6 no tick k7", c, 400);
    writeReg(8'hE0);
    check(cfgError === 1'b1, "R6 error k0", cfgError, 1);
    check(rdData === 8'hC0, "R2 readback k0", rdData, 'hC0);
    waitTick(400, c);
    check(c == 400, "R6 no tick k0", c, 400);

    // external timer source, k = 8, timer period 6 clocks (R8, R3)
    writeReg(8'h08);
    check(cfgError === 1'b0, "R7 legal k8", cfgError, 0);
    repeat (2) @(negedge clk);
    tmrRun = 1;
    waitTick(200, c);
    check(c < 200, "R8 first timer tick", c, 0);
    @(negedge clk);
    waitTick(100, c);
    check(c == 47, "R8 timer period", c + 1, 48);
    @(negedge clk);
    waitTick(100, c);
    check(c == 47, "R8 timer period again", c + 1, 48);
    tmrRun = 0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(8 * 150000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule